// File: doc/BRIEF.md
# Stereo Multi-Format Serial Audio Port

This block connects a stereo audio data path to a three-wire serial audio link: a bit clock, a frame clock whose level names the channel, and one serial data line in each direction. It runs entirely on the system clock. The bit clock and the frame clock come from an external master and are sampled as ordinary inputs. An edge detector picks out the bit-clock edge on which data is valid and the opposite edge on which outgoing data is driven.

On the receive side, serial bits are gathered into 20-bit two's-complement words. The input framing is chosen at run time from five layouts: I2S, left-justified, and right-justified with 20, 18 or 16 significant bits. Words shorter than 20 bits are sign-extended. A left/right pair is presented with a one-cycle strobe once per frame. On the transmit side, a pair of 20-bit words is loaded through a strobe and sent MSB first in either I2S or left-justified framing. A newly loaded pair takes effect at the start of the next left half-frame.

The mode register is written through a strobe and holds the input framing code, the output framing bit and the edge polarity bit. Frames must carry at least 21 bit clocks per half-frame, and the bit clock must run at no more than a quarter of the system clock.

Top module: `serial_audio_port`

## Requirements
- R1: After reset every output is zero and the mode register is all zeros, which selects I2S input, I2S output and rising-edge data, so that a stream in those settings is handled without any mode write.
- R2: Input code 0 (I2S): the channel MSB is taken on the second valid edge after a frame-clock change, 20 bits are taken, and frame clock low marks the left channel.
- R3: Input code 1 (left-justified): the MSB is taken on the first valid edge after a frame-clock change, 20 bits are taken, and frame clock high marks the left channel.
- R4: Input codes 2, 3 and 4 (right-justified 20, 18 and 16 bits): the LSB is the last bit before a frame-clock change, bits ahead of the sample width are ignored, the word is sign-extended to 20 bits, and frame clock high marks the left channel.
- R5: Input codes 5, 6 and 7 are reserved and never raise the receive strobe.
- R6: The receive strobe is a single-cycle pulse, raised once per frame after the right word completes, and only when the left word of the same frame came first. A mode write discards a pending left word.
- R7: Polarity bit 0 makes rising bit-clock edges the valid edges and falling edges the drive edges. Polarity bit 1 swaps them. The setting applies to both directions.
- R8: The serial output changes only in the cycle after a drive edge has been detected.
- R9: Output bit 0 selects I2S output (MSB at the second valid edge of the half, frame clock low for left). Output bit 1 selects left-justified output (MSB at the first valid edge, frame clock high for left). Bits outside the 20-bit window are zero.
- R10: A pair taken by the load strobe is sent from the next start of a left half-frame, under the selected output framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_in_fmt | input | 3 | Input framing code (0 I2S, 1 left-justified, 2/3/4 right-justified 20/18/16, 5-7 reserved) |
| mode_out_lj | input | 1 | Output framing: 0 I2S, 1 left-justified |
| mode_fall | input | 1 | Valid-edge polarity: 0 rising, 1 falling |
| bit_clk | input | 1 | Serial bit clock from the link master |
| frame_clk | input | 1 | Frame clock (channel select) from the link master |
| ser_in | input | 1 | Serial receive data |
| ser_out | output | 1 | Serial transmit data |
| tx_load | input | 1 | Load strobe for the transmit pair |
| tx_left | input | 20 | Left transmit word |
| tx_right | input | 20 | Right transmit word |
| rx_left | output | 20 | Received left word, sign-extended |
| rx_right | output | 20 | Received right word, sign-extended |
| rx_valid | output | 1 | One-cycle strobe marking a new received pair |

## Verification
Every combination of the eight input codes, both output framings and both polarities is driven with several frames of arithmetically generated samples, some positive and some negative. Bits outside each sample window are filled with ones, so a window that is off by one bit shows up as a wrong value. The right-justified codes carry samples whose sign bit sits at different positions, which separates correct sign extension from plain zero padding. In the mixed cases, the input and output framings use opposite frame-clock levels for the left channel, which separates the channel decode of the receiver from that of the transmitter. The polarity sweep shows whether data is taken on the selected edge, because the bench changes data only on the other edge.

// File: rtl/sap_pkg.sv
package sap_pkg;
  localparam int unsigned SAMPLE_W = 20;

  localparam logic [2:0] FMT_I2S  = 3'd0;
  localparam logic [2:0] FMT_LJ   = 3'd1;
  localparam logic [2:0] FMT_RJ20 = 3'd2;
  localparam logic [2:0] FMT_RJ18 = 3'd3;
  localparam logic [2:0] FMT_RJ16 = 3'd4;

  typedef struct packed {
    logic [2:0] in_fmt;
    logic       out_lj;
    logic       fall;
  } port_mode_t;
endpackage

// File: rtl/sap_edge.sv
module sap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_sel,
  input  logic bit_clk,
  input  logic frame_clk,
  input  logic ser_in,
  output logic smp_edge,
  output logic drv_edge,
  output logic lr_q,
  output logic sd_q
);
  logic bclk_q, bclk_q2;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      bclk_q2 <= 1'b0;
      lr_q    <= 1'b0;
      sd_q    <= 1'b0;
    end else begin
      bclk_q  <= bit_clk;
      bclk_q2 <= bclk_q;
      lr_q    <= frame_clk;
      sd_q    <= ser_in;
    end
  end

  always_comb begin
    rise     = bclk_q & ~bclk_q2;
    fall     = ~bclk_q & bclk_q2;
    smp_edge = fall_sel ? fall : rise;
    drv_edge = fall_sel ? rise : fall;
  end
endmodule

// File: rtl/sap_rx.sv
module sap_rx #(
  parameter int unsigned W = sap_pkg::SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_edge,
  input  logic         lr,
  input  logic         sd,
  input  logic [2:0]   in_fmt,
  input  logic         clr,
  output logic [W-1:0] rx_left,
  output logic [W-1:0] rx_right,
  output logic         rx_valid
);
  import sap_pkg::*;
  localparam int unsigned CNT_W = $clog2(W + 2);

  logic [W-1:0]     sr_q, sr_d, hold_q, hold_d, outl_d, outr_d, word_full, cap_word;
  logic [CNT_W-1:0] cnt_q, cnt_d, k, k_nx;
  logic             lrp_q, lrp_d, seen_q, seen_d, vld_d;
  logic             trans, cap, cap_left;

  always_comb begin
    trans     = (lr != lrp_q);
    k         = trans ? '0 : cnt_q;
    k_nx      = (k == '1) ? k : k + 1'b1;
    word_full = {sr_q[W-2:0], sd};
    cap       = 1'b0;
    cap_left  = 1'b0;
    cap_word  = word_full;
    case (in_fmt)
      FMT_I2S: begin
        cap      = (k == CNT_W'(W));
        cap_left = ~lr;
      end
      FMT_LJ: begin
        cap      = (k == CNT_W'(W - 1));
        cap_left = lr;
      end
      FMT_RJ20: begin
        cap      = trans;
        cap_left = lrp_q;
        cap_word = sr_q;
      end
      FMT_RJ18: begin
        cap      = trans;
        cap_left = lrp_q;
        cap_word = {{2{sr_q[W-3]}}, sr_q[W-3:0]};
      end
      FMT_RJ16: begin
        cap      = trans;
        cap_left = lrp_q;
        cap_word = {{4{sr_q[W-5]}}, sr_q[W-5:0]};
      end
      default: cap = 1'b0;
    endcase

    sr_d   = sr_q;
    lrp_d  = lrp_q;
    cnt_d  = cnt_q;
    hold_d = hold_q;
    seen_d = seen_q;
    outl_d = rx_left;
    outr_d = rx_right;
    vld_d  = 1'b0;
    if (smp_edge) begin
      sr_d  = word_full;
      lrp_d = lr;
      cnt_d = k_nx;
      if (cap) begin
        if (cap_left) begin
          hold_d = cap_word;
          seen_d = 1'b1;
        end else if (seen_q) begin
          outl_d = hold_q;
          outr_d = cap_word;
          vld_d  = 1'b1;
          seen_d = 1'b0;
        end
      end
    end
    if (clr) seen_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= '0;
      lrp_q    <= 1'b0;
      cnt_q    <= '0;
      hold_q   <= '0;
      seen_q   <= 1'b0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      sr_q     <= sr_d;
      lrp_q    <= lrp_d;
      cnt_q    <= cnt_d;
      hold_q   <= hold_d;
      seen_q   <= seen_d;
      rx_left  <= outl_d;
      rx_right <= outr_d;
      rx_valid <= vld_d;
    end
  end
endmodule

// File: rtl/sap_tx.sv
module sap_tx #(
  parameter int unsigned W = sap_pkg::SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         drv_edge,
  input  logic         lr,
  input  logic         out_lj,
  input  logic         tx_load,
  input  logic [W-1:0] tx_left,
  input  logic [W-1:0] tx_right,
  output logic         ser_out
);
  localparam int unsigned CNT_W = $clog2(W + 2);

  logic [W-1:0]     pend_l, pend_r, act_l, act_r, cur_l, cur_r, word, word_sh;
  logic [CNT_W-1:0] cnt_q, k, k_nx, idx;
  logic             lrp_q, trans, left_half, load_now, in_rng, sd_d;

  always_comb begin
    trans     = (lr != lrp_q);
    k         = trans ? '0 : cnt_q;
    k_nx      = (k == '1) ? k : k + 1'b1;
    left_half = out_lj ? lr : ~lr;
    load_now  = trans & left_half;
    cur_l     = load_now ? pend_l : act_l;
    cur_r     = load_now ? pend_r : act_r;
    word      = left_half ? cur_l : cur_r;
    if (out_lj) begin
      idx    = k;
      in_rng = (k < CNT_W'(W));
    end else begin
      idx    = k - 1'b1;
      in_rng = (k != '0) && (k <= CNT_W'(W));
    end
    word_sh = word << idx;
    sd_d    = in_rng & word_sh[W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l <= '0;
      pend_r <= '0;
    end else if (tx_load) begin
      pend_l <= tx_left;
      pend_r <= tx_right;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_l   <= '0;
      act_r   <= '0;
      lrp_q   <= 1'b0;
      cnt_q   <= '0;
      ser_out <= 1'b0;
    end else if (drv_edge) begin
      lrp_q   <= lr;
      cnt_q   <= k_nx;
      ser_out <= sd_d;
      if (load_now) begin
        act_l <= pend_l;
        act_r <= pend_r;
      end
    end
  end
endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port #(
  parameter int unsigned WORD_W = sap_pkg::SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [2:0]        mode_in_fmt,
  input  logic              mode_out_lj,
  input  logic              mode_fall,
  input  logic              bit_clk,
  input  logic              frame_clk,
  input  logic              ser_in,
  output logic              ser_out,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              rx_valid
);
  import sap_pkg::*;

  port_mode_t mode_q, mode_d;
  logic       smp_edge, drv_edge, lr_q, sd_q;
  logic [2:0] fmt_in;

  always_comb begin
    mode_d = mode_q;
    if (mode_wr) mode_d = '{in_fmt: mode_in_fmt, out_lj: mode_out_lj, fall: mode_fall};
    fmt_in = mode_q.in_fmt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  sap_edge u_edge (
    .clk(clk), .rst_n(rst_n), .fall_sel(mode_q.fall),
    .bit_clk(bit_clk), .frame_clk(frame_clk), .ser_in(ser_in),
    .smp_edge(smp_edge), .drv_edge(drv_edge), .lr_q(lr_q), .sd_q(sd_q)
  );

  sap_rx #(.W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .smp_edge(smp_edge), .lr(lr_q), .sd(sd_q),
    .in_fmt(fmt_in), .clr(mode_wr),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  sap_tx #(.W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .drv_edge(drv_edge), .lr(lr_q),
    .out_lj(mode_q.out_lj), .tx_load(tx_load),
    .tx_left(tx_left), .tx_right(tx_right), .ser_out(ser_out)
  );
endmodule

// File: rtl/sap_chk.sv
module sap_chk #(
  parameter int unsigned W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         smp_edge,
  input logic         drv_edge,
  input logic [2:0]   fmt_in,
  input logic         ser_out,
  input logic         rx_valid,
  input logic [W-1:0] rx_right
);
  // R5
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(fmt_in) <= 3'd4));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7
  valid_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(smp_edge));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_out) |-> $past(drv_edge));

  // R4
  rj16_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && $past(fmt_in) == 3'd4) |->
      ((&rx_right[W-1:W-5]) || !(|rx_right[W-1:W-5])));
endmodule

bind serial_audio_port sap_chk #(.W(WORD_W)) u_sap_chk (
  .clk(clk), .rst_n(rst_n), .smp_edge(smp_edge), .drv_edge(drv_edge),
  .fmt_in(fmt_in), .ser_out(ser_out), .rx_valid(rx_valid), .rx_right(rx_right)
);

// File: tb/serial_audio_port_bench.sv
module serial_audio_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [2:0]  mode_in_fmt = 3'd0;
  logic        mode_out_lj = 1'b0;
  logic        mode_fall = 1'b0;
  logic        bit_clk = 1'b0;
  logic        frame_clk = 1'b0;
  logic        ser_in = 1'b0;
  logic        ser_out;
  logic        tx_load = 1'b0;
  logic [19:0] tx_left = '0, tx_right = '0;
  logic [19:0] rx_left, rx_right;
  logic        rx_valid;

  int checks = 0;
  int fails = 0;
  logic drv_lvl = 1'b0;
  logic [19:0] q_l[$], q_r[$];
  int q_f[$];

  always #10 clk = ~clk;

  serial_audio_port u_serial_audio_port (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in_fmt(mode_in_fmt),
    .mode_out_lj(mode_out_lj), .mode_fall(mode_fall), .bit_clk(bit_clk),
    .frame_clk(frame_clk), .ser_in(ser_in), .ser_out(ser_out), .tx_load(tx_load),
    .tx_left(tx_left), .tx_right(tx_right), .rx_left(rx_left), .rx_right(rx_right),
    .rx_valid(rx_valid)
  );

  task automatic check(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  function automatic string rx_tag(input int f);
    if (f == 0) return "R2 R7";
    if (f == 1) return "R3 R7";
    return "R4 R7";
  endfunction

  // Receive monitor: R6 pairing and ordering
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (q_l.size() == 0) begin
        check(1'b0, "R5 R6 unexpected strobe", rx_left, 20'h0);
      end else begin
        logic [19:0] el, er;
        int ef;
        el = q_l.pop_front();
        er = q_r.pop_front();
        ef = q_f.pop_front();
        check(rx_left == el, {rx_tag(ef), " R6 left"}, rx_left, el);
        check(rx_right == er, {rx_tag(ef), " R6 right"}, rx_right, er);
      end
    end
  end

  function automatic logic [19:0] sx(input logic [19:0] v, input int n);
    logic signed [19:0] t;
    t = $signed(v << (20 - n));
    return 20'(t >>> (20 - n));
  endfunction

  function automatic int rj_len(input int fmt);
    return 20 - 2 * (fmt - 2);
  endfunction

  function automatic logic in_bit(input int fmt, input logic [19:0] w, input int p);
    if (fmt == 0) return (p >= 1 && p <= 20) ? w[20 - p] : 1'b1;
    if (fmt == 1) return (p < 20) ? w[19 - p] : 1'b1;
    if (fmt <= 4) return (p >= 32 - rj_len(fmt)) ? w[31 - p] : 1'b1;
    return w[p % 20];
  endfunction

  task automatic slot(input logic lr, input logic d, output logic got);
    bit_clk   = drv_lvl;
    frame_clk = lr;
    ser_in    = d;
    repeat (4) @(negedge clk);
    bit_clk = ~drv_lvl;
    got     = ser_out;
    repeat (4) @(negedge clk);
  endtask

  task automatic mode_write(input int fmt, input logic olj, input logic pol);
    mode_in_fmt = 3'(fmt);
    mode_out_lj = olj;
    mode_fall   = pol;
    mode_wr     = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_cfg(input int fmt, input logic olj, input logic pol, input bit wr, input int cfg);
    logic [19:0] txl, txr, l, r, w, dec, exp_tx;
    logic in_left, lrv, got;
    string ttag;
    txl = 20'((cfg * 32'h2468B + 32'h13579) & 32'hFFFFF);
    txr = ~txl ^ 20'(cfg);
    tx_left  = txl;
    tx_right = txr;
    tx_load  = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    if (wr) mode_write(fmt, olj, pol);
    drv_lvl = pol;
    in_left = (fmt == 0) ? 1'b0 : 1'b1;
    for (int p = 0; p < 4; p++) slot(~in_left, 1'b0, got);
    if (wr) mode_write(fmt, olj, pol);
    for (int f = 0; f < 4; f++) begin
      l = 20'((cfg * 32'h0B1D3 + f * 32'h1357F + 32'h5A5A5) & 32'hFFFFF);
      r = 20'((cfg * 32'h3C0F1 + f * 32'h8642B + 32'hA0A09) & 32'hFFFFF);
      if (fmt <= 1 || (fmt <= 4 && f < 3)) begin
        q_l.push_back(fmt <= 1 ? l : sx(l, rj_len(fmt)));
        q_r.push_back(fmt <= 1 ? r : sx(r, rj_len(fmt)));
        q_f.push_back(fmt);
      end
      for (int h = 0; h < 2; h++) begin
        w   = (h == 0) ? l : r;
        lrv = (h == 0) ? in_left : ~in_left;
        dec = '0;
        for (int p = 0; p < 32; p++) begin
          slot(lrv, in_bit(fmt, w, p), got);
          if (olj) begin
            if (p < 20) dec[19 - p] = got;
          end else if (p >= 1 && p <= 20) begin
            dec[20 - p] = got;
          end
        end
        if (f >= 1) begin
          exp_tx = (lrv == olj) ? txl : txr;
          ttag = $sformatf("R9 R10 R7 out_lj=%0d pol=%0d", olj, pol);
          check(dec == exp_tx, ttag, dec, exp_tx);
        end
      end
    end
    repeat (4) @(negedge clk);
    check(q_l.size() == 0, $sformatf("R6 R5 missing strobes fmt=%0d", fmt),
          20'(q_l.size()), 20'h0);
    q_l.delete();
    q_r.delete();
    q_f.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R6 watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state of outputs
    check(rx_valid == 1'b0, "R1 rx_valid", 20'(rx_valid), 20'h0);
    check(ser_out == 1'b0, "R1 ser_out", 20'(ser_out), 20'h0);
    check(rx_left == '0, "R1 rx_left", rx_left, 20'h0);
    check(rx_right == '0, "R1 rx_right", rx_right, 20'h0);
    // R1: default mode handles I2S in/out rising edge with no write
    run_cfg(0, 1'b0, 1'b0, 1'b0, 99);
    for (int pol = 0; pol < 2; pol++)
      for (int olj = 0; olj < 2; olj++)
        for (int fmt = 0; fmt < 8; fmt++)
          run_cfg(fmt, 1'(olj), 1'(pol), 1'b1, pol * 16 + olj * 8 + fmt);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule